// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs the external bus cycle of a small processor whose low address byte shares its pins with the data byte. The core offers a request: a direction (read or write), a space (memory or I/O), a 20-bit address, a write byte, a two-bit segment code and the current interrupt-enable flag. The sequencer accepts the request and steps through the phases T1, T2, T3, any number of wait phases Tw and T4. In each phase it drives the shared low byte, the middle address byte, the top address/status nibble, an address latch enable and an active-low read strobe.

In T1 the low byte and the top nibble carry address. An external latch captures it on the latch enable. From T2 onward the low byte carries data, or it is released for a read. The top nibble then carries status. The slave stretches the cycle by holding READY low at the end of T3 or of any Tw. Read data returns to the core with a one-cycle done pulse in T4. Two float inputs, for hold acknowledge and interrupt acknowledge, turn off the output enables of the pins they govern. Each pin group has its own output enable, so the pads can be tri-stated outside the block.

Top module: `mbus_cycle_seq`

## Requirements
- R1: A cycle runs T1, T2, T3, zero or more Tw, then T4. `reqReady` is high exactly in idle and in T4. A request with `reqValid` high is taken at an edge where `reqReady` is high, and T1 follows at once. So back-to-back cycles go from T4 straight to T1. From T4 with no request the sequencer returns to idle.
- R2: The low byte is driven with address bits 7..0 in T1. On a write it is driven with the write byte in T2, T3, Tw and T4. On a read it is released (`adOe` low) from T2 to T4.
- R3: The middle byte carries address bits 15..8 and is driven in every phase from T1 to T4.
- R4: In T1 the top nibble carries address bits 19..16 for a memory cycle and 0000 for an I/O cycle.
- R5: From T2 to T4 the top nibble carries status. Bit 3 is 0. Bit 2 is `intEn` as sampled at the previous clock edge. Bits 1..0 are the segment code: 00 alternate data, 01 stack, 10 code or none, 11 data.
- R6: `rdN` is low only in T2, T3 and Tw of a read cycle. `adOe` is never high while `rdN` is low.
- R7: `readyIn` is sampled at the edge that ends T3 and at the edge that ends each Tw. Low gives another Tw; high gives T4.
- R8: On a read, `adIn` is captured into `rspData` at the edge that ends the last T3 or Tw. `rspData` holds until the next read capture. `rspDone` is high for exactly the T4 cycle of every read and write.
- R9: `aleOut` is high in T1 only.
- R10: While `holdAck` is high, `adOe`, `aMidOe`, `aTopOe` and `rdOe` are low. While `intAck` is high, `adOe` and `aMidOe` are low.
- R11: After reset the sequencer is idle. In idle no bus group is enabled except the read strobe. `rdN` is high, `aleOut` and `rspDone` are low, and `rspData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core offers a bus request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory |
| reqAddr | input | 20 | Request address |
| reqWdata | input | 8 | Write byte |
| reqSeg | input | 2 | Segment code for status |
| intEn | input | 1 | Interrupt-enable flag |
| readyIn | input | 1 | Slave ready, already synchronized |
| holdAck | input | 1 | Hold acknowledge float request |
| intAck | input | 1 | Interrupt acknowledge float request |
| adIn | input | 8 | Low byte as seen at the pads |
| reqReady | output | 1 | Request can be taken this cycle |
| adOut | output | 8 | Low address/data byte |
| adOe | output | 1 | Low byte output enable |
| aMidOut | output | 8 | Address bits 15..8 |
| aMidOe | output | 1 | Middle byte output enable |
| aTopOut | output | 4 | Address 19..16 or status |
| aTopOe | output | 1 | Top nibble output enable |
| aleOut | output | 1 | Address latch enable |
| rdN | output | 1 | Active-low read strobe |
| rdOe | output | 1 | Read strobe output enable |
| rspData | output | 8 | Captured read data |
| rspDone | output | 1 | Cycle-complete pulse in T4 |

## Verification
Every output is registered state decoded without further delay. The phase outputs therefore move one clock edge after the inputs that caused them. A request taken at an edge shows T1 outputs right after that edge. READY sampled high at the edge that ends T3 or Tw gives T4 outputs, the done pulse and the new `rspData` right after that same edge. Status bit 2 reflects `intEn` one edge late. The float enables, in contrast, act in the same cycle. The bench keeps a behavioural phase model that advances on each rising edge with the inputs held there. It compares every output at the falling edge, before the next inputs are applied, so each expectation is due exactly one edge after its stimulus.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  typedef struct packed {
    logic loadReq;
    logic capData;
    logic addrPhase;
    logic statusPhase;
    logic readStrobe;
    logic dataDrive;
    logic done;
  } ctl_s;
endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   readyIn,
  output logic   reqReady,
  output ctl_s   ctl
);
  phase_e phase, phaseNext;
  logic   curWrite;

  assign reqReady = (phase == PH_IDLE) || (phase == PH_T4);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: phaseNext = reqValid ? PH_T1 : PH_IDLE;
      PH_T1:   phaseNext = PH_T2;
      PH_T2:   phaseNext = PH_T3;
      PH_T3,
      PH_TW:   phaseNext = readyIn ? PH_T4 : PH_TW;
      PH_T4:   phaseNext = reqValid ? PH_T1 : PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      curWrite <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (reqReady && reqValid) curWrite <= reqWrite;
    end
  end

  logic midCycle;
  assign midCycle = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);

  always_comb begin
    ctl             = '0;
    ctl.loadReq     = reqReady && reqValid;
    ctl.capData     = ((phase == PH_T3) || (phase == PH_TW)) && readyIn && !curWrite;
    ctl.addrPhase   = (phase == PH_T1);
    ctl.statusPhase = midCycle || (phase == PH_T4);
    ctl.readStrobe  = midCycle && !curWrite;
    ctl.dataDrive   = curWrite && (midCycle || (phase == PH_T4));
    ctl.done        = (phase == PH_T4);
  end

  // R1: fixed phase order after T1 and T2
  a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T1) |=> (phase == PH_T2));
  a_r1_t2_to_t3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_T2) |=> (phase == PH_T3));
  // R7: READY low at end of T3/Tw inserts a wait phase
  a_r7_wait_insert: assert property (@(posedge clk) disable iff (!rstN)
    (((phase == PH_T3) || (phase == PH_TW)) && !readyIn) |=> (phase == PH_TW));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !ctl.done);
endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int DataW = 8,
  parameter int MidW  = 8,
  parameter int TopW  = 4,
  parameter int SegW  = 2,
  localparam int AddrW = DataW + MidW + TopW,
  localparam int PadW  = TopW - SegW - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_s             ctl,
  input  logic             reqIo,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqWdata,
  input  logic [SegW-1:0]  reqSeg,
  input  logic             intEn,
  input  logic             holdAck,
  input  logic             intAck,
  input  logic [DataW-1:0] adIn,
  output logic [DataW-1:0] adOut,
  output logic             adOe,
  output logic [MidW-1:0]  aMidOut,
  output logic             aMidOe,
  output logic [TopW-1:0]  aTopOut,
  output logic             aTopOe,
  output logic             aleOut,
  output logic             rdN,
  output logic             rdOe,
  output logic [DataW-1:0] rspData,
  output logic             rspDone
);
  logic [AddrW-1:0] addrQ;
  logic [DataW-1:0] wdQ;
  logic [SegW-1:0]  segQ;
  logic             ioQ;
  logic             ieQ;
  logic [DataW-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
      segQ  <= '0;
      ioQ   <= 1'b0;
      ieQ   <= 1'b0;
      rdQ   <= '0;
    end else begin
      ieQ <= intEn;
      if (ctl.loadReq) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
        segQ  <= reqSeg;
        ioQ   <= reqIo;
      end
      if (ctl.capData) rdQ <= adIn;
    end
  end

  logic [TopW-1:0] statusWord;
  generate
    if (PadW > 0) begin : g_pad
      assign statusWord = {{PadW{1'b0}}, ieQ, segQ};
    end else begin : g_nopad
      assign statusWord = {ieQ, segQ};
    end
  endgenerate

  logic [TopW-1:0] topAddr;
  assign topAddr = ioQ ? '0 : addrQ[AddrW-1 -: TopW];

  logic cycleOn;
  assign cycleOn = ctl.addrPhase || ctl.statusPhase;

  assign adOut   = ctl.addrPhase ? addrQ[DataW-1:0] : wdQ;
  assign adOe    = (ctl.addrPhase || ctl.dataDrive) && !holdAck && !intAck;
  assign aMidOut = addrQ[DataW +: MidW];
  assign aMidOe  = cycleOn && !holdAck && !intAck;
  assign aTopOut = ctl.addrPhase ? topAddr : statusWord;
  assign aTopOe  = cycleOn && !holdAck;
  assign aleOut  = ctl.addrPhase;
  assign rdN     = !ctl.readStrobe;
  assign rdOe    = !holdAck;
  assign rspData = rdQ;
  assign rspDone = ctl.done;

  // R9: latch enable never lasts two cycles
  a_r9_ale_pulse: assert property (@(posedge clk) disable iff (!rstN)
    aleOut |=> !aleOut);
  // R8: read data changes only at a capture edge
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.capData) |=> $stable(rspData));
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int DataW = 8,
  parameter int MidW  = 8,
  parameter int TopW  = 4,
  parameter int SegW  = 2,
  localparam int AddrW = DataW + MidW + TopW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqIo,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqWdata,
  input  logic [SegW-1:0]  reqSeg,
  input  logic             intEn,
  input  logic             readyIn,
  input  logic             holdAck,
  input  logic             intAck,
  input  logic [DataW-1:0] adIn,
  output logic             reqReady,
  output logic [DataW-1:0] adOut,
  output logic             adOe,
  output logic [MidW-1:0]  aMidOut,
  output logic             aMidOe,
  output logic [TopW-1:0]  aTopOut,
  output logic             aTopOe,
  output logic             aleOut,
  output logic             rdN,
  output logic             rdOe,
  output logic [DataW-1:0] rspData,
  output logic             rspDone
);
  ctl_s ctl;

  mbus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .readyIn  (readyIn),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  mbus_dp #(
    .DataW (DataW),
    .MidW  (MidW),
    .TopW  (TopW),
    .SegW  (SegW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqIo    (reqIo),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqSeg   (reqSeg),
    .intEn    (intEn),
    .holdAck  (holdAck),
    .intAck   (intAck),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .aMidOut  (aMidOut),
    .aMidOe   (aMidOe),
    .aTopOut  (aTopOut),
    .aTopOe   (aTopOe),
    .aleOut   (aleOut),
    .rdN      (rdN),
    .rdOe     (rdOe),
    .rspData  (rspData),
    .rspDone  (rspDone)
  );

  // R6: the read strobe never overlaps a driven low byte
  a_r6_rd_float: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN) |-> (!adOe));
endmodule

// File: tb/sim_mbus_cycle_seq.sv
module sim_mbus_cycle_seq;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [1:0]  reqSeg = '0;
  logic        intEn = 1'b0, readyIn = 1'b1, holdAck = 1'b0, intAck = 1'b0;
  logic [7:0]  adIn = '0;
  logic        reqReady, adOe, aMidOe, aTopOe, aleOut, rdN, rdOe, rspDone;
  logic [7:0]  adOut, aMidOut, rspData;
  logic [3:0]  aTopOut;

  int checks = 0;
  int failures = 0;

  always #(ClkPeriod/2) clk = ~clk;

  mbus_cycle_seq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqIo(reqIo), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSeg(reqSeg),
    .intEn(intEn), .readyIn(readyIn), .holdAck(holdAck), .intAck(intAck),
    .adIn(adIn), .reqReady(reqReady), .adOut(adOut), .adOe(adOe),
    .aMidOut(aMidOut), .aMidOe(aMidOe), .aTopOut(aTopOut), .aTopOe(aTopOe),
    .aleOut(aleOut), .rdN(rdN), .rdOe(rdOe), .rspData(rspData),
    .rspDone(rspDone)
  );

  // Behavioural model: 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4
  int          mSt;
  logic        mWr, mIo, mIe;
  logic [19:0] mAddr;
  logic [7:0]  mWd, mRd;
  logic [1:0]  mSeg;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt <= 0; mWr <= 0; mIo <= 0; mIe <= 0;
      mAddr <= '0; mWd <= '0; mRd <= '0; mSeg <= '0;
    end else begin
      mIe <= intEn;
      if (mSt == 0 || mSt == 5) begin
        if (reqValid) begin
          mSt <= 1; mWr <= reqWrite; mIo <= reqIo;
          mAddr <= reqAddr; mWd <= reqWdata; mSeg <= reqSeg;
        end else mSt <= 0;
      end else if (mSt == 1) mSt <= 2;
      else if (mSt == 2) mSt <= 3;
      else if (readyIn) begin
        if (!mWr) mRd <= adIn;
        mSt <= 5;
      end else mSt <= 4;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic inCyc, addrPh, lowDrv, midDrv, topDrv, rdAct;
    logic [3:0] topExp;
    inCyc  = (mSt >= 1 && mSt <= 5);
    addrPh = (mSt == 1);
    rdAct  = !mWr && (mSt >= 2 && mSt <= 4);
    lowDrv = (addrPh || (mWr && mSt >= 2 && mSt <= 5)) && !holdAck && !intAck;
    midDrv = inCyc && !holdAck && !intAck;
    topDrv = inCyc && !holdAck;
    topExp = addrPh ? (mIo ? 4'h0 : mAddr[19:16]) : {1'b0, mIe, mSeg};
    chk("R1 reqReady", 32'(reqReady), 32'(mSt == 0 || mSt == 5));
    chk("R2/R10 adOe", 32'(adOe), 32'(lowDrv));
    if (lowDrv) chk("R2 adOut", 32'(adOut), addrPh ? 32'(mAddr[7:0]) : 32'(mWd));
    chk("R3/R10 aMidOe", 32'(aMidOe), 32'(midDrv));
    if (midDrv) chk("R3 aMidOut", 32'(aMidOut), 32'(mAddr[15:8]));
    chk("R10 aTopOe", 32'(aTopOe), 32'(topDrv));
    if (inCyc) chk(addrPh ? "R4 aTopOut" : "R5 aTopOut", 32'(aTopOut), 32'(topExp));
    chk("R6 rdN", 32'(rdN), 32'(!rdAct));
    chk("R10 rdOe", 32'(rdOe), 32'(!holdAck));
    chk("R9 aleOut", 32'(aleOut), 32'(addrPh));
    chk("R7/R8 rspDone", 32'(rspDone), 32'(mSt == 5));
    chk("R8 rspData", 32'(rspData), 32'(mRd));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reqReady", 32'(reqReady), 32'd1);
    chk("R11 adOe", 32'(adOe), 32'd0);
    chk("R11 aMidOe", 32'(aMidOe), 32'd0);
    chk("R11 aTopOe", 32'(aTopOe), 32'd0);
    chk("R11 rdN", 32'(rdN), 32'd1);
    chk("R11 aleOut", 32'(aleOut), 32'd0);
    chk("R11 rspDone", 32'(rspDone), 32'd0);
    chk("R11 rspData", 32'(rspData), 32'd0);
    rstN = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      compareAll();
      reqValid = ($urandom_range(0, 9) < 6);
      reqWrite = $urandom_range(0, 1);
      reqIo    = ($urandom_range(0, 3) == 0);
      reqAddr  = 20'($urandom);
      reqWdata = 8'($urandom);
      reqSeg   = 2'($urandom);
      intEn    = $urandom_range(0, 1);
      readyIn  = (i < 200) ? 1'b1 : ($urandom_range(0, 9) < 6);
      holdAck  = ($urandom_range(0, 19) == 0);
      intAck   = ($urandom_range(0, 19) == 0);
      adIn     = 8'($urandom);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule